// File: doc/BRIEF.md
# SPI-Mode Card Block Write Engine

This block carries the data phase of a write to a memory card running in SPI mode, once the write command itself has been accepted elsewhere. A single start pulse captures a block count, a block size and a multi-block flag. For each block the engine emits one filler byte and a start token, streams the payload from a valid/ready byte input, appends a CRC16 of that payload, then hunts for the card's data response token and polls through the card's busy period. A multi-block write that completes every block is closed with a stop token and a final busy wait.

The engine does not shift bits itself. It drives one byte at a time into a byte-wide SPI exchanger through a request/acknowledge pair and receives the byte clocked in during the same exchange. When the transfer ends, a one-cycle done pulse comes with a status code that separates success, a rejected block and a busy timeout. Block count and block size are given minus one, so every value of those inputs is meaningful.

Top module: `sdspi_blkwr`

## Requirements
- R1: Each block starts with the byte 0xFF followed by a start token, 0xFC when `multi` was high at start and 0xFE otherwise.
- R2: Exactly `blk_size_m1`+1 payload bytes are taken per block, in stream order, and sent unchanged; `pl_ready` is high only while the engine waits for a payload byte with no SPI exchange in flight.
- R3: After the payload the engine sends the CRC16 of that block's payload (polynomial 0x1021, initial value 0x0000, bits taken most significant first), high byte first.
- R4: After the CRC the engine sends 0xFF bytes and reads at most RESP_TRIES of them; the first received byte with bit 4 clear is the response token, and if none appears the last byte read is decoded as the token.
- R5: A token whose low five bits are 0x05 accepts the block; any other token ends the transfer at once with status 1 (rejected), with no further SPI byte and no stop token.
- R6: After acceptance the engine sends 0xFF and reads until a received byte equals 0xFF, never ending on the first read of the wait; if BUSY_LIMIT reads pass without that, the transfer ends with status 2 (timeout).
- R7: When every block of a multi-block write is accepted and its busy wait ends, the engine sends 0xFF, then 0xFD, then runs a second busy wait under the R6 rule; a single-block write ends after its busy wait with no stop token.
- R8: `done` is high for exactly one cycle per transfer; `status` is 0 for success, 1 for rejected, 2 for timeout, and changes only in the cycle `done` is high.
- R9: `spi_req` stays high with `spi_tx` unchanged until `spi_ack` is seen, and each acknowledged exchange counts as one byte read on `spi_rx`.
- R10: A `start` pulse that arrives while a transfer is running has no effect on the byte sequence or the outcome.
- R11: After reset `spi_req`, `done` and `pl_ready` are low and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a transfer when the engine is idle |
| multi | input | 1 | Selects a multi-block write, sampled at start |
| blk_cnt_m1 | input | CNT_W | Number of blocks minus one, sampled at start |
| blk_size_m1 | input | SIZE_W | Payload bytes per block minus one, sampled at start |
| pl_valid | input | 1 | Payload byte available |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte taken this cycle when valid |
| spi_req | output | 1 | Byte exchange request to the SPI exchanger |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Exchange finished, spi_rx valid |
| spi_rx | input | 8 | Byte shifted in during the exchange |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 2 | 0 success, 1 rejected, 2 busy timeout |

## Verification
The bench builds the engine with SIZE_W=4, CNT_W=3, RESP_TRIES=8 and BUSY_LIMIT=16, CRC enabled. A 16-read busy limit makes both timeouts, inside a block and after the stop token, reachable in a few dozen cycles, while the 4-bit size field lets a full maximum-length block run quickly. The eight-try response window is kept at its working value so the latest-possible token and the no-token case are exercised exactly at the edge.

// File: rtl/sdspi_blkwr_pkg.sv
package sdspi_blkwr_pkg;

   typedef enum logic [1:0] {
      WR_OK      = 2'd0,
      WR_REJECT  = 2'd1,
      WR_TIMEOUT = 2'd2
   } wr_status_t;

   typedef enum logic [3:0] {
      S_IDLE,
      S_LEAD,
      S_TOKEN,
      S_DATA,
      S_CRC_HI,
      S_CRC_LO,
      S_RESP,
      S_BUSY,
      S_END_LEAD,
      S_END_TOKEN,
      S_END_BUSY
   } wr_state_t;

   localparam logic [7:0] FILL_BYTE   = 8'hFF;
   localparam logic [7:0] TOKEN_ONE   = 8'hFE;
   localparam logic [7:0] TOKEN_MANY  = 8'hFC;
   localparam logic [7:0] TOKEN_END   = 8'hFD;
   localparam logic [4:0] RESP_OK     = 5'h05;

   function automatic logic [15:0] crc16_step(input logic [15:0] cur, input logic [7:0] din);
      logic [15:0] c;
      logic        fb;
      c = cur;
      for (int i = 7; i >= 0; i--) begin
         fb = c[15] ^ din[i];
         c  = {c[14:0], 1'b0};
         if (fb) c = c ^ 16'h1021;
      end
      return c;
   endfunction

endpackage

// File: rtl/sdspi_blkwr_crc16.sv
module sdspi_blkwr_crc16
   import sdspi_blkwr_pkg::*;
#(
   parameter bit CRC_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        feed,
   input  logic [7:0]  din,
   output logic [15:0] crc_o
);

   generate
      if (CRC_EN) begin : g_crc
         logic [15:0] crc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      crc_q <= '0;
            else if (clear)  crc_q <= '0;
            else if (feed)   crc_q <= crc16_step(crc_q, din);
         end
         assign crc_o = crc_q;
      end else begin : g_nocrc
         logic unused_crc_in;
         assign unused_crc_in = ^{clk, rst_n, clear, feed, din};
         assign crc_o = 16'hFFFF;
      end
   endgenerate

endmodule

// File: rtl/sdspi_blkwr_poll.sv
module sdspi_blkwr_poll #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic first_o,
   output logic last_o
);

   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + CW'(1);
   end

   assign first_o = (cnt_q == '0);
   assign last_o  = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/sdspi_blkwr.sv
module sdspi_blkwr
   import sdspi_blkwr_pkg::*;
#(
   parameter int SIZE_W     = 9,
   parameter int CNT_W      = 16,
   parameter int RESP_TRIES = 8,
   parameter int BUSY_LIMIT = 3000000,
   parameter bit CRC_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              multi,
   input  logic [CNT_W-1:0]  blk_cnt_m1,
   input  logic [SIZE_W-1:0] blk_size_m1,
   input  logic              pl_valid,
   input  logic [7:0]        pl_data,
   output logic              pl_ready,
   output logic              spi_req,
   output logic [7:0]        spi_tx,
   input  logic              spi_ack,
   input  logic [7:0]        spi_rx,
   output logic              done,
   output logic [1:0]        status
);

   generate
      if (SIZE_W < 1) begin : g_bad_size
         $error("SIZE_W must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
      if (RESP_TRIES < 1) begin : g_bad_tries
         $error("RESP_TRIES must be at least 1");
      end
      if (BUSY_LIMIT < 2) begin : g_bad_busy
         $error("BUSY_LIMIT must be at least 2");
      end
   endgenerate

   wr_state_t         st_q;
   logic              multi_q;
   logic [SIZE_W-1:0] size_q;
   logic [SIZE_W-1:0] bytes_left_q;
   logic [CNT_W-1:0]  blks_left_q;
   logic              req_q;
   logic [7:0]        tx_q;
   logic              done_q;
   wr_status_t        status_q;

   logic              issue_ok;
   logic [7:0]        next_tx;
   logic              xfer_fire;
   logic              take;
   logic [15:0]       crc_val;
   logic              resp_last;
   logic              busy_first;
   logic              busy_last;
   logic              in_busy;
   logic              rx_idle;
   logic              busy_clear_ok;

   assign xfer_fire = req_q && spi_ack;
   assign pl_ready  = (st_q == S_DATA) && !req_q;
   assign take      = pl_ready && pl_valid;
   assign in_busy   = (st_q == S_BUSY) || (st_q == S_END_BUSY);
   assign rx_idle   = (spi_rx == FILL_BYTE);
   assign busy_clear_ok = !busy_first && rx_idle;

   // Byte to issue in each state
   always_comb begin
      next_tx = FILL_BYTE;
      unique case (st_q)
         S_TOKEN:     next_tx = multi_q ? TOKEN_MANY : TOKEN_ONE;
         S_DATA:      next_tx = pl_data;
         S_CRC_HI:    next_tx = crc_val[15:8];
         S_CRC_LO:    next_tx = crc_val[7:0];
         S_END_TOKEN: next_tx = TOKEN_END;
         default:     next_tx = FILL_BYTE;
      endcase
   end

   assign issue_ok = (st_q != S_IDLE) && !req_q && ((st_q != S_DATA) || pl_valid);

   sdspi_blkwr_crc16 #(.CRC_EN(CRC_EN)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st_q == S_TOKEN),
      .feed  (take),
      .din   (pl_data),
      .crc_o (crc_val)
   );

   logic unused_resp_first;
   sdspi_blkwr_poll #(.LIMIT(RESP_TRIES)) u_resp_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (st_q != S_RESP),
      .step    (xfer_fire && (st_q == S_RESP)),
      .first_o (unused_resp_first),
      .last_o  (resp_last)
   );

   sdspi_blkwr_poll #(.LIMIT(BUSY_LIMIT)) u_busy_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!in_busy),
      .step    (xfer_fire && in_busy),
      .first_o (busy_first),
      .last_o  (busy_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= S_IDLE;
         multi_q      <= 1'b0;
         size_q       <= '0;
         bytes_left_q <= '0;
         blks_left_q  <= '0;
         req_q        <= 1'b0;
         tx_q         <= FILL_BYTE;
         done_q       <= 1'b0;
         status_q     <= WR_OK;
      end else begin
         done_q <= 1'b0;
         if (st_q == S_IDLE) begin
            if (start) begin
               multi_q      <= multi;
               size_q       <= blk_size_m1;
               bytes_left_q <= blk_size_m1;
               blks_left_q  <= blk_cnt_m1;
               st_q         <= S_LEAD;
            end
         end else if (issue_ok) begin
            req_q <= 1'b1;
            tx_q  <= next_tx;
         end else if (xfer_fire) begin
            req_q <= 1'b0;
            unique case (st_q)
               S_LEAD:   st_q <= S_TOKEN;
               S_TOKEN:  st_q <= S_DATA;
               S_DATA: begin
                  if (bytes_left_q == '0) st_q <= S_CRC_HI;
                  else bytes_left_q <= bytes_left_q - SIZE_W'(1);
               end
               S_CRC_HI: st_q <= S_CRC_LO;
               S_CRC_LO: st_q <= S_RESP;
               S_RESP: begin
                  if (!spi_rx[4] || resp_last) begin
                     if (spi_rx[4:0] == RESP_OK) begin
                        st_q <= S_BUSY;
                     end else begin
                        st_q     <= S_IDLE;
                        done_q   <= 1'b1;
                        status_q <= WR_REJECT;
                     end
                  end
               end
               S_BUSY: begin
                  if (busy_clear_ok) begin
                     if (blks_left_q != '0) begin
                        blks_left_q  <= blks_left_q - CNT_W'(1);
                        bytes_left_q <= size_q;
                        st_q         <= S_LEAD;
                     end else if (multi_q) begin
                        st_q <= S_END_LEAD;
                     end else begin
                        st_q     <= S_IDLE;
                        done_q   <= 1'b1;
                        status_q <= WR_OK;
                     end
                  end else if (busy_last) begin
                     st_q     <= S_IDLE;
                     done_q   <= 1'b1;
                     status_q <= WR_TIMEOUT;
                  end
               end
               S_END_LEAD:  st_q <= S_END_TOKEN;
               S_END_TOKEN: st_q <= S_END_BUSY;
               S_END_BUSY: begin
                  if (busy_clear_ok) begin
                     st_q     <= S_IDLE;
                     done_q   <= 1'b1;
                     status_q <= WR_OK;
                  end else if (busy_last) begin
                     st_q     <= S_IDLE;
                     done_q   <= 1'b1;
                     status_q <= WR_TIMEOUT;
                  end
               end
               default: st_q <= S_IDLE;
            endcase
         end
      end
   end

   assign spi_req = req_q;
   assign spi_tx  = tx_q;
   assign done    = done_q;
   assign status  = status_q;

endmodule

// File: rtl/sdspi_blkwr_chk.sv
module sdspi_blkwr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_req,
   input logic [7:0] spi_tx,
   input logic       spi_ack,
   input logic       pl_ready,
   input logic       done,
   input logic [1:0] status
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx))); // R9

   AST_READY_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      pl_ready |-> !spi_req); // R2

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_STATUS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status) |-> done); // R8

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!spi_req && !pl_ready)); // R5

   AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      status != 2'd3); // R8

endmodule

bind sdspi_blkwr sdspi_blkwr_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .spi_req  (spi_req),
   .spi_tx   (spi_tx),
   .spi_ack  (spi_ack),
   .pl_ready (pl_ready),
   .done     (done),
   .status   (status)
);

// File: tb/sdspi_blkwr_bench.sv
`timescale 1ns/1ps
module sdspi_blkwr_bench;

   localparam int SIZE_W = 4;
   localparam int CNT_W  = 3;
   localparam int TRIES  = 8;
   localparam int BLIM   = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              multi = 1'b0;
   logic [CNT_W-1:0]  blk_cnt_m1 = '0;
   logic [SIZE_W-1:0] blk_size_m1 = '0;
   logic              pl_valid = 1'b0;
   logic [7:0]        pl_data = 8'h00;
   logic              pl_ready;
   logic              spi_req;
   logic [7:0]        spi_tx;
   logic              spi_ack = 1'b0;
   logic [7:0]        spi_rx = 8'hFF;
   logic              done;
   logic [1:0]        status;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0] exp_tx[$];
   logic [7:0] card_rx[$];
   string      exp_tag[$];
   logic [7:0] pay_q[$];

   always #4 clk = ~clk;

   sdspi_blkwr #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .RESP_TRIES(TRIES),
                 .BUSY_LIMIT(BLIM), .CRC_EN(1'b1)) u_sdspi_blkwr (
      .clk(clk), .rst_n(rst_n), .start(start), .multi(multi),
      .blk_cnt_m1(blk_cnt_m1), .blk_size_m1(blk_size_m1),
      .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
      .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
      .done(done), .status(status));

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c ^ {d, 8'h00};
      for (int b = 0; b < 8; b++)
         r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   task automatic push(input logic [7:0] tx, input logic [7:0] rx, input string tag);
      exp_tx.push_back(tx);
      card_rx.push_back(rx);
      exp_tag.push_back(tag);
   endtask

   task automatic add_busy(input int zeros);
      if (zeros < 0) begin
         for (int k = 0; k < BLIM; k++) push(8'hFF, 8'h00, "R6");
      end else begin
         push(8'hFF, 8'hFF, "R6");
         for (int k = 0; k < zeros; k++) push(8'hFF, 8'h00, "R6");
         push(8'hFF, 8'hFF, "R6");
      end
   endtask

   task automatic add_block(input bit m, input int size, input int seed,
                            input int resp_ff, input logic [7:0] code, input int busy_zeros);
      logic [15:0] c;
      logic [7:0]  d;
      c = 16'h0000;
      push(8'hFF, 8'hFF, "R1");
      push(m ? 8'hFC : 8'hFE, 8'hFF, "R1");
      for (int i = 0; i < size; i++) begin
         d = 8'((seed * 37 + i * 11 + 5) & 255);
         pay_q.push_back(d);
         push(d, 8'hFF, "R2");
         c = ref_crc(c, d);
      end
      push(c[15:8], 8'hFF, "R3");
      push(c[7:0], 8'hFF, "R3");
      for (int k = 0; k < resp_ff; k++) push(8'hFF, 8'hFF, "R4");
      push(8'hFF, code, "R4");
      if (code[4:0] == 5'h05) add_busy(busy_zeros);
   endtask

   task automatic add_stop(input int zeros);
      push(8'hFF, 8'hFF, "R7");
      push(8'hFD, 8'hFF, "R7");
      add_busy(zeros);
   endtask

   task automatic kick(input bit m, input int nblk, input int size);
      @(negedge clk);
      multi = m;
      blk_cnt_m1 = CNT_W'(nblk - 1);
      blk_size_m1 = SIZE_W'(size - 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_xfer(input logic [1:0] exp_st, input string tag);
      while (!done) @(negedge clk);
      check(status == exp_st, tag, "status at done", status, exp_st);
      check(exp_tx.size() == 0, "R5", "bytes left unsent", exp_tx.size(), 0);
      check(pay_q.size() == 0, "R2", "payload left untaken", pay_q.size(), 0);
      @(negedge clk);
      check(done == 1'b0, "R8", "done pulse width", done, 0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check(spi_req == 1'b0, "R5", "request after done", spi_req, 0);
      end
      check(status == exp_st, "R8", "status held", status, exp_st);
   endtask

   // Card model and scoreboard monitor
   initial begin : card
      int wait_cnt;
      int pat;
      logic [7:0] e;
      string t;
      wait_cnt = 0;
      pat = 0;
      forever begin
         @(negedge clk);
         if (spi_ack) begin
            spi_ack = 1'b0;
         end else if (spi_req) begin
            if (wait_cnt > 0) begin
               wait_cnt--;
            end else begin
               if (exp_tx.size() == 0) begin
                  check(1'b0, "R10", "unexpected SPI byte", spi_tx, 0);
                  spi_rx = 8'hFF;
               end else begin
                  e = exp_tx.pop_front();
                  t = exp_tag.pop_front();
                  spi_rx = card_rx.pop_front();
                  check(spi_tx == e, t, "SPI byte sent", spi_tx, e);
               end
               spi_ack = 1'b1;
               pat++;
               wait_cnt = pat % 3;
            end
         end
      end
   end

   // Payload source with stalls
   initial begin : feeder
      bit took;
      int gap;
      took = 1'b0;
      gap = 0;
      forever begin
         @(negedge clk);
         if (took) void'(pay_q.pop_front());
         gap++;
         pl_valid = (pay_q.size() > 0) && ((gap % 4) != 3);
         pl_data = (pay_q.size() > 0) ? pay_q[0] : 8'h00;
         #1;
         took = pl_valid && pl_ready;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11 reset state
      check(spi_req == 1'b0, "R11", "spi_req in reset", spi_req, 0);
      check(done == 1'b0, "R11", "done in reset", done, 0);
      check(pl_ready == 1'b0, "R11", "pl_ready in reset", pl_ready, 0);
      check(status == 2'd0, "R11", "status in reset", status, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Single block, prompt token, short busy: R1 R3 R6
      add_block(1'b0, 4, 1, 0, 8'hE5, 2);
      kick(1'b0, 1, 4);
      finish_xfer(2'd0, "R1");

      // Multi-block, three blocks, stop and busy: R7
      add_block(1'b1, 8, 2, 1, 8'h05, 0);
      add_block(1'b1, 8, 3, 3, 8'hE5, 4);
      add_block(1'b1, 8, 4, 0, 8'h25, 1);
      add_stop(3);
      kick(1'b1, 3, 8);
      finish_xfer(2'd0, "R7");

      // Token on last allowed try: R4
      add_block(1'b0, 3, 5, TRIES - 1, 8'h05, 0);
      kick(1'b0, 1, 3);
      finish_xfer(2'd0, "R4");

      // CRC rejected on block two, no stop token: R5
      add_block(1'b1, 5, 6, 0, 8'hE5, 1);
      add_block(1'b1, 5, 7, 2, 8'hEB, 0);
      kick(1'b1, 3, 5);
      finish_xfer(2'd1, "R5");

      // Write error token: R5
      add_block(1'b0, 2, 8, 1, 8'h0D, 0);
      kick(1'b0, 1, 2);
      finish_xfer(2'd1, "R5");

      // No token at all within the window: R4
      add_block(1'b0, 2, 9, TRIES - 1, 8'hFF, 0);
      kick(1'b0, 1, 2);
      finish_xfer(2'd1, "R4");

      // Busy never clears inside a block: R6
      add_block(1'b0, 3, 10, 0, 8'h05, -1);
      kick(1'b0, 1, 3);
      finish_xfer(2'd2, "R6");

      // Busy never clears after stop token: R7
      add_block(1'b1, 2, 11, 0, 8'h05, 0);
      add_block(1'b1, 2, 12, 0, 8'h05, 2);
      add_stop(-1);
      kick(1'b1, 2, 2);
      finish_xfer(2'd2, "R7");

      // Start pulse during a transfer is ignored: R10
      add_block(1'b0, 6, 13, 1, 8'h05, 3);
      kick(1'b0, 1, 6);
      repeat (8) @(negedge clk);
      multi = 1'b1;
      blk_cnt_m1 = 3'd5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finish_xfer(2'd0, "R10");

      // Multi with a single block still uses 0xFC and stop: R1 R7
      add_block(1'b1, 1, 14, 0, 8'h05, 0);
      add_stop(0);
      kick(1'b1, 1, 1);
      finish_xfer(2'd0, "R1");

      // Largest block size: R2 R3
      add_block(1'b0, 16, 15, 2, 8'hE5, 1);
      kick(1'b0, 1, 16);
      finish_xfer(2'd0, "R2");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule